// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block controls the power states of a pseudo-static memory through the memory's active-high power-down enable. When the supply is reported good, it keeps the chip enable inactive and the power-down enable low for a long settling interval. It then raises the power-down enable and finishes initialisation in one of two ways, chosen by a parameter. In the dummy-read variant it borrows the bus and runs a fixed number of full read cycles. In the hold variant it keeps the chip enable inactive for a second long interval. Only after that does it raise `ready`. Normal traffic is gated by `ready`.

A host can request power-down. The request is taken only while the bus controller reports idle. The sequencer then borrows the chip-enable, output-enable and write-enable pins through a request/grant pair, keeps the chip enable inactive for a short setup time, and drops the power-down enable. A wake request repeats the full initialisation. Power-down loses the array contents, so every completed wake raises a one-cycle `contents_lost` pulse together with `ready`. A drop of `supply_ok` returns the block to its off state in the next cycle from any state.

The pins are plain control and status wires. There is no data stream and no back-pressure. The only handshake is `bus_req`/`bus_gnt`, and the sequencer waits without limit for a grant it has requested. All long intervals come from a prescaled counter, so one tick is `TICK_DIV` clock cycles.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `supply_ok` is low after reset, `mem_ce2`=0, `mem_ce1_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `ready`=0 and `bus_req`=0.
- R2: After `supply_ok` rises, `mem_ce2` stays 0 with `mem_ce1_n`=1 for at least `HOLD_LO_TICKS*TICK_DIV` and at most that plus 3 cycles. It then rises once, as a single registered step.
- R3: With `USE_DUMMY`=1, once `mem_ce2` has risen and `bus_gnt` is high, exactly `NUM_RD` read cycles follow. In each, `mem_ce1_n` and `mem_oe_n` are low for `RD_CYC` cycles and `mem_we_n` stays 1. Each read is followed by `GAP_CYC` cycles with `mem_ce1_n` high. `ready` rises within 3 cycles after the last gap.
- R4: With `USE_DUMMY`=0, `mem_ce1_n` stays 1 for at least `HOLD_HI_TICKS*TICK_DIV` and at most that plus 3 cycles after `mem_ce2` rises. `ready` then rises, and no grant is needed.
- R5: A power-down request is taken when `ready`, `pd_req` and `bus_idle` are all high. `ready` then falls and `bus_req` rises. After `bus_gnt`, `mem_ce1_n` is held 1 for `PD_SETUP_CYC` cycles before `mem_ce2` falls, and `mem_ce2` falls within `PD_SETUP_CYC+3` cycles of the grant.
- R6: In power-down, `mem_ce2`=0, `ready`=0 and `mem_ce1_n`=1 until `wake_req`. A wake repeats the R2 hold and then the R3 or R4 path.
- R7: `contents_lost` is high for exactly one cycle, in the cycle `ready` rises at the end of a wake from power-down. It is never high after the initial power-up.
- R8: `host_err` is high in the cycle after one in which `host_acc` was high while `ready` was low. It stays low after accesses made while `ready` is high.
- R9: If `supply_ok` falls, the outputs take the R1 values in the next cycle.
- R10: `mem_ce2` changes only when `mem_ce1_n` is 1 both before and after the change. Every `mem_ce1_n` low pulse lasts at least `RD_CYC` cycles.
- R11: A `pd_req` made while `bus_idle` is 0 has no effect: `ready`=1, `mem_ce2`=1 and `bus_req`=0 are kept.
- R12: In the dummy-read variant, no read starts without `bus_gnt`. `mem_ce1_n` stays 1, `bus_req` stays 1 and `ready` stays 0 while the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply valid; low forces the off state |
| pd_req | input | 1 | Host request to enter power-down |
| wake_req | input | 1 | Host request to leave power-down |
| bus_idle | input | 1 | Bus controller has no transfer in flight |
| bus_req | output | 1 | Sequencer asks for the memory control pins |
| bus_gnt | input | 1 | Bus controller hands the control pins over |
| host_acc | input | 1 | Host attempts a memory access |
| host_err | output | 1 | Pulse: access attempted while not ready |
| ready | output | 1 | Memory usable for normal traffic |
| contents_lost | output | 1 | Pulse: ready after a power-down exit, data gone |
| mem_ce1_n | output | 1 | Memory chip enable, active low (valid when granted) |
| mem_ce2 | output | 1 | Memory power-down enable, low = power-down |
| mem_oe_n | output | 1 | Memory output enable, active low (valid when granted) |
| mem_we_n | output | 1 | Memory write enable, active low, held high |

## Verification
The hardest state to reach is a dummy-read exit that stalls on a withheld grant. The stimulus gets there by dropping `supply_ok` from the ready state and powering up again with `bus_gnt` low, so the dummy-read variant parks after its hold interval while the hold-path instance, which shares the same inputs, completes. Both variants run side by side on one stimulus. A negedge monitor per instance records the rise and fall points of `mem_ce2`, `mem_ce1_n` pulse and gap lengths, and `contents_lost` pulses. The bench compares these against arithmetic from the parameters. Power-down entry is first held at the grant stage to show that `mem_ce2` cannot fall before the pins are handed over.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_HOLD_LO,
    ST_DGRANT,
    ST_DUMMY,
    ST_SETTLE,
    ST_READY,
    ST_PD_GRANT,
    ST_PD_SETUP,
    ST_PD
  } seq_st_e;

endpackage

// File: rtl/psram_interval_ctr.sv
// Counts a loaded number of ticks, each tick PRESCALE cycles long.
module psram_interval_ctr #(
  parameter int PRESCALE  = 125,
  parameter int MAX_COUNT = 400,
  localparam int CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic          done
);

  logic [CW-1:0] rem;
  logic          tick;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre <= '0;
        end else if (kill || start) begin
          pre <= PW'(PRESCALE - 1);
        end else if (rem != '0) begin
          pre <= (pre == '0) ? PW'(PRESCALE - 1) : pre - 1'b1;
        end
      end
      assign tick = (pre == '0);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
    end else if (kill) begin
      rem <= '0;
    end else if (start) begin
      rem <= count;
    end else if (rem != '0 && tick) begin
      rem <= rem - 1'b1;
    end
  end

  assign done = (rem == '0);

endmodule

// File: rtl/psram_dummy_rd.sv
// Issues NUM_RD read cycles: chip enable low RD_CYC, then high GAP_CYC.
module psram_dummy_rd #(
  parameter int RD_CYC  = 12,
  parameter int GAP_CYC = 2,
  parameter int NUM_RD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic start,
  output logic busy,
  output logic ce1_n,
  output logic oe_n
);

  localparam int MXC = (RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC;
  localparam int CNW = $clog2(MXC + 1);
  localparam int NW  = $clog2(NUM_RD + 1);

  logic           low_ph;
  logic [CNW-1:0] cnt;
  logic [NW-1:0]  nrd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      low_ph <= 1'b0;
      cnt    <= '0;
      nrd    <= '0;
    end else if (kill) begin
      busy   <= 1'b0;
      low_ph <= 1'b0;
      cnt    <= '0;
      nrd    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      low_ph <= 1'b1;
      cnt    <= CNW'(RD_CYC - 1);
      nrd    <= '0;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (low_ph) begin
        low_ph <= 1'b0;
        cnt    <= CNW'(GAP_CYC - 1);
      end else if (nrd == NW'(NUM_RD - 1)) begin
        busy <= 1'b0;
      end else begin
        nrd    <= nrd + 1'b1;
        low_ph <= 1'b1;
        cnt    <= CNW'(RD_CYC - 1);
      end
    end
  end

  assign ce1_n = ~low_ph;
  assign oe_n  = ~low_ph;

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int TICK_DIV      = 125,
  parameter int HOLD_LO_TICKS = 360,
  parameter int HOLD_HI_TICKS = 310,
  parameter int PD_SETUP_CYC  = 13,
  parameter int RD_CYC        = 12,
  parameter int GAP_CYC       = 2,
  parameter int NUM_RD        = 2,
  parameter bit USE_DUMMY     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pd_req,
  input  logic wake_req,
  input  logic bus_idle,
  output logic bus_req,
  input  logic bus_gnt,
  input  logic host_acc,
  output logic host_err,
  output logic ready,
  output logic contents_lost,
  output logic mem_ce1_n,
  output logic mem_ce2,
  output logic mem_oe_n,
  output logic mem_we_n
);
  import psram_seq_pkg::*;

  localparam int LMAX = (HOLD_LO_TICKS > HOLD_HI_TICKS) ? HOLD_LO_TICKS : HOLD_HI_TICKS;
  localparam int LCW  = $clog2(LMAX + 1);
  localparam int SCW  = $clog2(PD_SETUP_CYC + 1);

  seq_st_e  st, st_nx;
  logic     ce2_q, ce2_nx;
  logic     from_pd, lost_q, err_q;
  logic     start_long, sel_hi, done_long;
  logic     start_pd, done_pd;
  logic     start_dr, dr_busy, dr_ce1_n, dr_oe_n;
  logic     kill;
  logic [LCW-1:0] long_cnt;

  assign kill     = ~supply_ok;
  assign long_cnt = sel_hi ? LCW'(HOLD_HI_TICKS) : LCW'(HOLD_LO_TICKS);

  psram_interval_ctr #(.PRESCALE(TICK_DIV), .MAX_COUNT(LMAX)) u_long (
    .clk(clk), .rst_n(rst_n), .kill(kill), .start(start_long),
    .count(long_cnt), .done(done_long)
  );

  psram_interval_ctr #(.PRESCALE(1), .MAX_COUNT(PD_SETUP_CYC)) u_setup (
    .clk(clk), .rst_n(rst_n), .kill(kill), .start(start_pd),
    .count(SCW'(PD_SETUP_CYC)), .done(done_pd)
  );

  generate
    if (USE_DUMMY) begin : g_dummy
      psram_dummy_rd #(.RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC), .NUM_RD(NUM_RD)) u_drd (
        .clk(clk), .rst_n(rst_n), .kill(kill), .start(start_dr),
        .busy(dr_busy), .ce1_n(dr_ce1_n), .oe_n(dr_oe_n)
      );
    end else begin : g_hold
      assign dr_busy  = 1'b0;
      assign dr_ce1_n = 1'b1;
      assign dr_oe_n  = 1'b1;
    end
  endgenerate

  always_comb begin
    st_nx      = st;
    ce2_nx     = ce2_q;
    start_long = 1'b0;
    sel_hi     = 1'b0;
    start_pd   = 1'b0;
    start_dr   = 1'b0;
    case (st)
      ST_OFF: if (supply_ok) begin
        st_nx      = ST_HOLD_LO;
        start_long = 1'b1;
      end
      ST_HOLD_LO: if (done_long) begin
        ce2_nx = 1'b1;
        if (USE_DUMMY) begin
          st_nx = ST_DGRANT;
        end else begin
          st_nx      = ST_SETTLE;
          start_long = 1'b1;
          sel_hi     = 1'b1;
        end
      end
      ST_DGRANT: if (bus_gnt) begin
        st_nx    = ST_DUMMY;
        start_dr = 1'b1;
      end
      ST_DUMMY:    if (!dr_busy) st_nx = ST_READY;
      ST_SETTLE:   if (done_long) st_nx = ST_READY;
      ST_READY:    if (pd_req && bus_idle) st_nx = ST_PD_GRANT;
      ST_PD_GRANT: if (bus_gnt) begin
        st_nx    = ST_PD_SETUP;
        start_pd = 1'b1;
      end
      ST_PD_SETUP: if (done_pd) begin
        ce2_nx = 1'b0;
        st_nx  = ST_PD;
      end
      ST_PD: if (wake_req) begin
        st_nx      = ST_HOLD_LO;
        start_long = 1'b1;
      end
      default: st_nx = ST_OFF;
    endcase
    if (!supply_ok) begin
      st_nx      = ST_OFF;
      ce2_nx     = 1'b0;
      start_long = 1'b0;
      start_pd   = 1'b0;
      start_dr   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      ce2_q   <= 1'b0;
      from_pd <= 1'b0;
      lost_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      ce2_q  <= ce2_nx;
      err_q  <= host_acc && (st != ST_READY);
      lost_q <= from_pd && (st_nx == ST_READY) && (st != ST_READY);
      if (st == ST_PD && st_nx == ST_HOLD_LO) begin
        from_pd <= 1'b1;
      end else if (st_nx == ST_READY || st_nx == ST_OFF) begin
        from_pd <= 1'b0;
      end
    end
  end

  assign ready         = (st == ST_READY);
  assign bus_req       = (st != ST_OFF) && (st != ST_READY);
  assign host_err      = err_q;
  assign contents_lost = lost_q;
  assign mem_ce2       = ce2_q;
  assign mem_ce1_n     = dr_ce1_n;
  assign mem_oe_n      = dr_oe_n;
  assign mem_we_n      = 1'b1;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int RD_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic pd_req,
  input logic bus_idle,
  input logic bus_req,
  input logic host_acc,
  input logic host_err,
  input logic ready,
  input logic contents_lost,
  input logic mem_ce1_n,
  input logic mem_ce2,
  input logic mem_we_n
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!mem_ce1_n) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R10: power-down enable moves only with chip enable inactive around it
  a_r10_ce2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce2 != $past(mem_ce2)) && $past(supply_ok) |-> mem_ce1_n && $past(mem_ce1_n));

  // R10: chip enable low pulses are never shorter than one read
  a_r10_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce1_n) && $past(supply_ok) |-> low_run >= RD_CYC);

  // R5: ready never coexists with a pin request or power-down
  a_r5_ready_state: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce2 && !bus_req);

  // R9: supply loss forces the off outputs next cycle
  a_r9_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !ready && !mem_ce2 && !bus_req);

  // R7: lost pulse only coincides with ready rising
  a_r7_lost_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    contents_lost |-> $rose(ready));

  // R8: error pulse follows an access made while not ready
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> $past(host_acc) && !$past(ready));

  // R11: leaving ready with supply present needs a request on an idle bus
  a_r11_pd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) && $past(supply_ok) && supply_ok |-> $past(pd_req) && $past(bus_idle));

  // R3: write enable is never driven active
  a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n) mem_we_n);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(.RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
  .bus_idle(bus_idle), .bus_req(bus_req), .host_acc(host_acc),
  .host_err(host_err), .ready(ready), .contents_lost(contents_lost),
  .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n)
);

// File: tb/sim_psram_pwr_seq.sv
module psram_mon (
  input  logic clk,
  input  logic clr,
  input  logic ce1_n,
  input  logic ce2,
  input  logic oe_n,
  input  logic we_n,
  input  logic ready,
  input  logic lost,
  output int   ce2_rise_at,
  output int   ce2_fall_at,
  output int   ready_rise_at,
  output int   lost_at,
  output int   n_lost,
  output int   n_pulse,
  output int   min_low,
  output int   max_low,
  output int   min_gap,
  output int   n_bad
);
  int cyc, low_run, high_run;
  logic p_ce1_n, p_ce2, p_ready;

  always @(negedge clk) begin
    if (clr) begin
      cyc = 0; low_run = 0; high_run = 0;
      ce2_rise_at = -1; ce2_fall_at = -1; ready_rise_at = -1; lost_at = -1;
      n_lost = 0; n_pulse = 0; min_low = 1 << 20; max_low = 0;
      min_gap = 1 << 20; n_bad = 0;
    end else begin
      cyc = cyc + 1;
      if (ce2 && !p_ce2) ce2_rise_at = cyc;
      if (!ce2 && p_ce2) ce2_fall_at = cyc;
      if (ce2 != p_ce2 && (!ce1_n || !p_ce1_n)) n_bad = n_bad + 1;
      if (oe_n != ce1_n || !we_n) n_bad = n_bad + 1;
      if (ready && !p_ready) ready_rise_at = cyc;
      if (lost) begin n_lost = n_lost + 1; lost_at = cyc; end
      if (!ce1_n) begin
        if (p_ce1_n && n_pulse > 0 && high_run < min_gap) min_gap = high_run;
        low_run = low_run + 1;
      end else begin
        if (!p_ce1_n) begin
          n_pulse = n_pulse + 1;
          if (low_run < min_low) min_low = low_run;
          if (low_run > max_low) max_low = low_run;
          high_run = 0;
        end
        high_run = high_run + 1;
        low_run = 0;
      end
    end
    p_ce1_n = ce1_n; p_ce2 = ce2; p_ready = ready;
  end
endmodule

module sim_psram_pwr_seq;
  localparam int P   = 4;
  localparam int HL  = 5;
  localparam int HH  = 6;
  localparam int PS  = 3;
  localparam int RD  = 4;
  localparam int GAP = 2;
  localparam int NR  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 0, pd_req = 0, wake_req = 0, bus_idle = 0, bus_gnt = 0, host_acc = 0;
  logic clr = 0;

  logic breq0, err0, rdy0, lost0, ce1n0, ce20, oen0, wen0;
  logic breq1, err1, rdy1, lost1, ce1n1, ce21, oen1, wen1;

  int total = 0;
  int bad = 0;
  int wd = 0;

  always #4 clk = ~clk;

  psram_pwr_seq #(.TICK_DIV(P), .HOLD_LO_TICKS(HL), .HOLD_HI_TICKS(HH), .PD_SETUP_CYC(PS),
                  .RD_CYC(RD), .GAP_CYC(GAP), .NUM_RD(NR), .USE_DUMMY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req), .wake_req(wake_req),
    .bus_idle(bus_idle), .bus_req(breq0), .bus_gnt(bus_gnt), .host_acc(host_acc),
    .host_err(err0), .ready(rdy0), .contents_lost(lost0), .mem_ce1_n(ce1n0),
    .mem_ce2(ce20), .mem_oe_n(oen0), .mem_we_n(wen0));

  psram_pwr_seq #(.TICK_DIV(P), .HOLD_LO_TICKS(HL), .HOLD_HI_TICKS(HH), .PD_SETUP_CYC(PS),
                  .RD_CYC(RD), .GAP_CYC(GAP), .NUM_RD(NR), .USE_DUMMY(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req), .wake_req(wake_req),
    .bus_idle(bus_idle), .bus_req(breq1), .bus_gnt(bus_gnt), .host_acc(host_acc),
    .host_err(err1), .ready(rdy1), .contents_lost(lost1), .mem_ce1_n(ce1n1),
    .mem_ce2(ce21), .mem_oe_n(oen1), .mem_we_n(wen1));

  int r0_c2r, r0_c2f, r0_rdy, r0_lat, r0_nl, r0_np, r0_mnl, r0_mxl, r0_mg, r0_bad;
  int r1_c2r, r1_c2f, r1_rdy, r1_lat, r1_nl, r1_np, r1_mnl, r1_mxl, r1_mg, r1_bad;

  psram_mon m0 (.clk(clk), .clr(clr), .ce1_n(ce1n0), .ce2(ce20), .oe_n(oen0), .we_n(wen0),
    .ready(rdy0), .lost(lost0), .ce2_rise_at(r0_c2r), .ce2_fall_at(r0_c2f),
    .ready_rise_at(r0_rdy), .lost_at(r0_lat), .n_lost(r0_nl), .n_pulse(r0_np),
    .min_low(r0_mnl), .max_low(r0_mxl), .min_gap(r0_mg), .n_bad(r0_bad));

  psram_mon m1 (.clk(clk), .clr(clr), .ce1_n(ce1n1), .ce2(ce21), .oe_n(oen1), .we_n(wen1),
    .ready(rdy1), .lost(lost1), .ce2_rise_at(r1_c2r), .ce2_fall_at(r1_c2f),
    .ready_rise_at(r1_rdy), .lost_at(r1_lat), .n_lost(r1_nl), .n_pulse(r1_np),
    .min_low(r1_mnl), .max_low(r1_mxl), .min_gap(r1_mg), .n_bad(r1_bad));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  // u0 expectations after a hold with dummy reads (R2, R3)
  task automatic chk_dummy_exit(input string tag);
    chk(r0_c2r >= HL*P && r0_c2r <= HL*P + 3, {tag, " R2 u0 ce2 rise"}, r0_c2r, HL*P);
    chk(r0_np == NR, {tag, " R3 u0 read count"}, r0_np, NR);
    chk(r0_mnl == RD && r0_mxl == RD, {tag, " R3 u0 low width"}, r0_mnl, RD);
    chk(r0_mg == GAP, {tag, " R3 u0 gap"}, r0_mg, GAP);
    chk(r0_rdy - r0_c2r >= NR*(RD+GAP) && r0_rdy - r0_c2r <= NR*(RD+GAP) + 3,
        {tag, " R3 u0 ready delay"}, r0_rdy - r0_c2r, NR*(RD+GAP));
    chk(r0_bad == 0, {tag, " R10 u0 pin rules"}, r0_bad, 0);
    chk(r1_c2r >= HL*P && r1_c2r <= HL*P + 3, {tag, " R2 u1 ce2 rise"}, r1_c2r, HL*P);
    chk(r1_np == 0, {tag, " R4 u1 no pulses"}, r1_np, 0);
    chk(r1_rdy - r1_c2r >= HH*P && r1_rdy - r1_c2r <= HH*P + 3,
        {tag, " R4 u1 ready delay"}, r1_rdy - r1_c2r, HH*P);
    chk(r1_bad == 0, {tag, " R10 u1 pin rules"}, r1_bad, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 idle state
    chk(ce20 == 0 && ce21 == 0, "R1 ce2 low", ce20, 0);
    chk(ce1n0 && oen0 && wen0 && ce1n1, "R1 strobes high", ce1n0, 1);
    chk(!rdy0 && !rdy1 && !breq0 && !breq1, "R1 not ready, no request", rdy0, 0);

    // R8 access while not ready
    host_acc = 1'b1;
    cyc(1);
    host_acc = 1'b0;
    chk(err0 && err1, "R8 error pulse", err0, 1);
    cyc(1);
    chk(!err0 && !err1, "R8 pulse is single", err0, 0);

    // R2/R3/R4 power-up, grant available
    bus_gnt = 1'b1;
    supply_ok = 1'b1;
    clear_mon();
    cyc(90);
    chk_dummy_exit("pwrup");
    chk(r0_nl == 0 && r1_nl == 0, "R7 no lost pulse at power-up", r0_nl + r1_nl, 0);
    chk(rdy0 && rdy1, "R3 both ready", rdy0 + rdy1, 2);

    // R8 access while ready
    host_acc = 1'b1;
    cyc(1);
    host_acc = 1'b0;
    chk(!err0 && !err1, "R8 no error when ready", err0, 0);

    // R11 request with a busy bus is ignored
    bus_gnt = 1'b0;
    bus_idle = 1'b0;
    pd_req = 1'b1;
    cyc(20);
    chk(rdy0 && rdy1 && ce20 && ce21 && !breq0 && !breq1, "R11 ignored", rdy0, 1);

    // R5 request accepted, grant withheld
    bus_idle = 1'b1;
    cyc(10);
    pd_req = 1'b0;
    chk(!rdy0 && !rdy1 && breq0 && breq1, "R5 request raised", breq0, 1);
    chk(ce20 && ce21, "R5 ce2 held without grant", ce20, 1);
    bus_gnt = 1'b1;
    clear_mon();
    cyc(30);
    chk(r0_c2f >= PS + 1 && r0_c2f <= PS + 3, "R5 u0 setup before ce2 fall", r0_c2f, PS + 1);
    chk(r1_c2f >= PS + 1 && r1_c2f <= PS + 3, "R5 u1 setup before ce2 fall", r1_c2f, PS + 1);
    chk(r0_bad == 0 && r1_bad == 0, "R10 entry pin rules", r0_bad + r1_bad, 0);
    // R6 stays down
    chk(!ce20 && !ce21 && !rdy0 && !rdy1, "R6 held in power-down", ce20, 0);
    chk(r0_np == 0 && r1_np == 0 && ce1n0 && ce1n1, "R6 ce1 high in power-down", r0_np, 0);
    host_acc = 1'b1;
    cyc(1);
    host_acc = 1'b0;
    chk(err0 && err1, "R8 error in power-down", err0, 1);

    // R6/R7 wake
    wake_req = 1'b1;
    clear_mon();
    wake_req = 1'b0;
    cyc(90);
    chk_dummy_exit("wake");
    chk(r0_nl == 1 && r0_lat == r0_rdy, "R7 u0 lost with ready", r0_nl, 1);
    chk(r1_nl == 1 && r1_lat == r1_rdy, "R7 u1 lost with ready", r1_nl, 1);

    // R9 supply drop
    supply_ok = 1'b0;
    cyc(1);
    chk(!ce20 && !ce21 && !rdy0 && !rdy1 && !breq0 && !breq1 && ce1n0,
        "R9 off next cycle", ce20 + rdy0 + breq0, 0);

    // R12 power-up with grant withheld
    bus_gnt = 1'b0;
    supply_ok = 1'b1;
    clear_mon();
    cyc(60);
    chk(!rdy0 && breq0 && ce20 && ce1n0 && r0_np == 0, "R12 u0 waits for grant", r0_np, 0);
    chk(rdy1, "R4 u1 ready without grant", rdy1, 1);
    bus_gnt = 1'b1;
    cyc(30);
    chk(rdy0 && r0_np == NR && r0_mnl == RD, "R12 u0 reads after grant", r0_np, NR);
    chk(r0_nl == 0, "R7 no lost pulse after supply cycle", r0_nl, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule